// File: doc/BRIEF.md
# Out-of-Order Operand-Ready Issue Queue

This block sits between instruction decode and the execution units. Decode is split in two phases. In the first phase an incoming decoded instruction is accepted into the queue only if a slot is free, the functional unit it targets is not marked busy, and no unfinished instruction is already due to write its destination register. On acceptance each source operand is marked ready or waiting, depending on whether an earlier unfinished instruction is still going to produce it.

In the second phase, queued entries watch a completion broadcast. A broadcast carrying a register tag marks that tag as written and wakes every entry waiting on it. Each cycle the oldest entry whose two sources are both ready is released to execution with its unit, source tags and destination tag. An older entry stalled on a long-latency result, such as a divide, does not hold back younger independent entries.

The queue keeps its entries in age order and closes the gap left by a released entry. At most one entry is released per cycle, and a released entry is always taken.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `relValid` is low, and `issueReady` is high for a free unit and any destination.
- R2: `issueReady` is low whenever `unitBusy[issueUnit]` is set.
- R3: `issueReady` is low while the queue holds 8 entries.
- R4: `issueReady` is low when `issueDst` equals the destination of an accepted instruction whose completion has not yet been broadcast.
- R5: An instruction is accepted on a clock edge where `issueValid` and `issueReady` are both high. If neither source is pending at that edge, it is offered on `relValid` right after that edge.
- R6: An entry with a pending source is not released until a broadcast (`cplValid` with `cplTag`) of that tag. It becomes releasable right after that broadcast edge.
- R7: A broadcast in the same cycle that an instruction reading that tag is accepted counts as ready for that instruction.
- R8: When several entries are ready, the one accepted earliest is released. One entry is released per cycle, and it leaves the queue at the next edge.
- R9: A younger entry whose sources are ready is released while an older entry still waits on a long-running producer.
- R10: `relUnit`, `relSrcA`, `relSrcB` and `relDst` carry the values given at acceptance.
- R11: A broadcast of a tag ends its pending state, so an instruction writing that register is accepted again after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A decoded instruction is presented |
| issueUnit | input | 2 | Target functional unit |
| issueSrcA | input | 5 | First source register tag |
| issueSrcB | input | 5 | Second source register tag |
| issueDst | input | 5 | Destination register tag |
| unitBusy | input | 4 | Per-unit structural busy flag |
| cplValid | input | 1 | Completion broadcast valid |
| cplTag | input | 5 | Destination tag of the completed instruction |
| issueReady | output | 1 | Presented instruction can be accepted this cycle |
| relValid | output | 1 | An entry is released this cycle |
| relUnit | output | 2 | Unit of the released entry |
| relSrcA | output | 5 | First source tag of the released entry |
| relSrcB | output | 5 | Second source tag of the released entry |
| relDst | output | 5 | Destination tag of the released entry |

## Verification
`issueReady` is a combinational function of the registered state and the presented unit and destination. The bench therefore samples it one time unit after driving the inputs, before the edge that would accept the instruction. The release outputs depend only on registered state. An instruction accepted with ready sources, or an entry woken by a broadcast, shows up on the release port right after that same edge, and it is sampled at the following falling edge. A released entry leaves at the next rising edge, so a sequence of ready entries is checked one falling edge at a time, in age order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int DEPTH     = 8;
  localparam int NUM_UNITS = 4;
  localparam int NUM_REGS  = 32;

  localparam int TAG_W  = $clog2(NUM_REGS);
  localparam int UNIT_W = $clog2(NUM_UNITS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [UNIT_W-1:0] unit_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // One queue slot: payload plus a ready flag per source
  typedef struct packed {
    logic  vld;
    unit_t unit;
    tag_t  srcA;
    tag_t  srcB;
    tag_t  dst;
    logic  rdyA;
    logic  rdyB;
  } entry_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic push;
    logic pop;
    idx_t popIdx;
    idx_t wrIdx;
    logic newRdyA;
    logic newRdyB;
  } strobe_t;
endpackage

// File: rtl/iq_data.sv
module iq_data
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  unit_t            inUnit,
  input  tag_t             inSrcA,
  input  tag_t             inSrcB,
  input  tag_t             inDst,
  input  logic             cplValid,
  input  tag_t             cplTag,
  output logic [DEPTH-1:0] validVec,
  output logic [DEPTH-1:0] readyVec,
  output entry_t           relEntry
);
  entry_t q     [DEPTH];
  entry_t qNext [DEPTH];

  // Collapse over the released slot, wake sources, then append at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      entry_t upper;
      entry_t cur;
      upper = (i == DEPTH - 1) ? '0 : q[(i + 1) % DEPTH];
      cur   = (strb.pop && (IDX_W'(i) >= strb.popIdx)) ? upper : q[i];
      if (cplValid && cur.vld && cur.srcA == cplTag) cur.rdyA = 1'b1;
      if (cplValid && cur.vld && cur.srcB == cplTag) cur.rdyB = 1'b1;
      if (strb.push && IDX_W'(i) == strb.wrIdx) begin
        cur = '{vld: 1'b1, unit: inUnit, srcA: inSrcA, srcB: inSrcB,
                dst: inDst, rdyA: strb.newRdyA, rdyB: strb.newRdyB};
      end
      qNext[i] = cur;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) q[i] <= '0;
      else       q[i] <= qNext[i];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      validVec[i] = q[i].vld;
      readyVec[i] = q[i].vld && q[i].rdyA && q[i].rdyB;
    end
  end

  assign relEntry = q[strb.popIdx];
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  unit_t                issueUnit,
  input  tag_t                 issueSrcA,
  input  tag_t                 issueSrcB,
  input  tag_t                 issueDst,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic                 cplValid,
  input  tag_t                 cplTag,
  input  logic [DEPTH-1:0]     validVec,
  input  logic [DEPTH-1:0]     readyVec,
  output strobe_t              strb,
  output logic                 issueReady
);
  logic [NUM_REGS-1:0] pending;
  logic [NUM_REGS-1:0] setMask;
  logic [NUM_REGS-1:0] clrMask;
  logic [CNT_W-1:0]    occCnt;
  logic [CNT_W-1:0]    wrTmp;
  logic                full;

  always_comb begin
    occCnt = '0;
    for (int i = 0; i < DEPTH; i++) occCnt = occCnt + CNT_W'(validVec[i]);
  end

  assign full       = (occCnt == CNT_W'(DEPTH));
  assign issueReady = !full && !unitBusy[issueUnit] && !pending[issueDst];

  // Oldest ready slot: lowest index wins
  always_comb begin
    strb.popIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (readyVec[i]) strb.popIdx = IDX_W'(i);
    end
  end

  assign strb.pop  = |readyVec;
  assign strb.push = issueValid && issueReady;
  assign wrTmp     = occCnt - CNT_W'(strb.pop);
  assign strb.wrIdx = wrTmp[IDX_W-1:0];

  assign strb.newRdyA = !pending[issueSrcA] || (cplValid && cplTag == issueSrcA);
  assign strb.newRdyB = !pending[issueSrcB] || (cplValid && cplTag == issueSrcB);

  always_comb begin
    setMask = '0;
    clrMask = '0;
    if (strb.push) setMask[issueDst] = 1'b1;
    if (cplValid)  clrMask[cplTag]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrMask) | setMask;
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         issueValid,
  input  logic [iq_pkg::UNIT_W-1:0]    issueUnit,
  input  logic [iq_pkg::TAG_W-1:0]     issueSrcA,
  input  logic [iq_pkg::TAG_W-1:0]     issueSrcB,
  input  logic [iq_pkg::TAG_W-1:0]     issueDst,
  input  logic [iq_pkg::NUM_UNITS-1:0] unitBusy,
  input  logic                         cplValid,
  input  logic [iq_pkg::TAG_W-1:0]     cplTag,
  output logic                         issueReady,
  output logic                         relValid,
  output logic [iq_pkg::UNIT_W-1:0]    relUnit,
  output logic [iq_pkg::TAG_W-1:0]     relSrcA,
  output logic [iq_pkg::TAG_W-1:0]     relSrcB,
  output logic [iq_pkg::TAG_W-1:0]     relDst
);
  import iq_pkg::*;

  strobe_t          strb;
  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] readyVec;
  entry_t           relEntry;

  iq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueDst(issueDst),
    .unitBusy(unitBusy), .cplValid(cplValid), .cplTag(cplTag),
    .validVec(validVec), .readyVec(readyVec), .strb(strb), .issueReady(issueReady)
  );

  iq_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .inUnit(issueUnit),
    .inSrcA(issueSrcA), .inSrcB(issueSrcB), .inDst(issueDst),
    .cplValid(cplValid), .cplTag(cplTag), .validVec(validVec),
    .readyVec(readyVec), .relEntry(relEntry)
  );

  assign relValid = strb.pop;
  assign relUnit  = relEntry.unit;
  assign relSrcA  = relEntry.srcA;
  assign relSrcB  = relEntry.srcB;
  assign relDst   = relEntry.dst;
endmodule

// File: rtl/iq_checker.sv
module iq_checker
  import iq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input unit_t                issueUnit,
  input tag_t                 issueDst,
  input logic [NUM_UNITS-1:0] unitBusy,
  input logic                 cplValid,
  input tag_t                 cplTag,
  input logic                 issueReady,
  input logic                 relValid
);
  logic [CNT_W:0]      occ;
  logic [NUM_REGS-1:0] chkPend;
  logic                accepted;

  assign accepted = issueValid && issueReady;

  // Occupancy and in-flight destinations rebuilt from port traffic
  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ     <= '0;
      chkPend <= '0;
    end else begin
      occ <= occ + (CNT_W + 1)'(accepted) - (CNT_W + 1)'(relValid);
      for (int r = 0; r < NUM_REGS; r++) begin
        if (accepted && issueDst == TAG_W'(r))     chkPend[r] <= 1'b1;
        else if (cplValid && cplTag == TAG_W'(r))  chkPend[r] <= 1'b0;
      end
    end
  end

  p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    occ == '0 |-> !relValid);

  p_busy_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && unitBusy[issueUnit] |-> !issueReady);

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ == (CNT_W + 1)'(DEPTH) |-> !issueReady);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (CNT_W + 1)'(DEPTH));

  p_waw_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    chkPend[issueDst] |-> !issueReady);
endmodule

bind issue_queue iq_checker u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
  .issueDst(issueDst), .unitBusy(unitBusy), .cplValid(cplValid),
  .cplTag(cplTag), .issueReady(issueReady), .relValid(relValid)
);

// File: tb/tb_issue_queue.sv
module tb_issue_queue;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       issueValid;
  logic [1:0] issueUnit;
  logic [4:0] issueSrcA, issueSrcB, issueDst;
  logic [3:0] unitBusy;
  logic       cplValid;
  logic [4:0] cplTag;
  logic       issueReady, relValid;
  logic [1:0] relUnit;
  logic [4:0] relSrcA, relSrcB, relDst;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;
  logic rdyObs;
  logic [3:0] busyDrv = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  issue_queue dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueDst(issueDst),
    .unitBusy(unitBusy), .cplValid(cplValid), .cplTag(cplTag),
    .issueReady(issueReady), .relValid(relValid), .relUnit(relUnit),
    .relSrcA(relSrcA), .relSrcB(relSrcB), .relDst(relDst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, sample issueReady, pass a rising edge
  task automatic cyc(input bit iv, input int u, input int a, input int b, input int d,
                     input bit cv, input int ct);
    issueValid = iv;
    issueUnit  = 2'(u);
    issueSrcA  = 5'(a);
    issueSrcB  = 5'(b);
    issueDst   = 5'(d);
    unitBusy   = busyDrv;
    cplValid   = cv;
    cplTag     = 5'(ct);
    #1 rdyObs = issueReady;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expRel(input string req, input int d);
    chk(relValid == 1'b1, req, int'(relValid), 1);
    chk(relDst == 5'(d), req, int'(relDst), d);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rstN = 1'b0;
    issueValid = 0; issueUnit = 0; issueSrcA = 0; issueSrcB = 0; issueDst = 0;
    unitBusy = 0; cplValid = 0; cplTag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: empty after reset
    chk(relValid == 1'b0, "R1", int'(relValid), 0);
    chk(issueReady == 1'b1, "R1", int'(issueReady), 1);

    // R2: every busy unit against every target unit
    for (int bu = 0; bu < 4; bu++) begin
      for (int u = 0; u < 4; u++) begin
        busyDrv = 4'(1 << bu);
        cyc(0, u, 0, 0, 0, 0, 0);
        chk(rdyObs == (u != bu), "R2", int'(rdyObs), int'(u != bu));
      end
    end
    busyDrv = '0;

    // R5, R10: independent instruction released right after acceptance
    cyc(1, 0, 1, 2, 10, 0, 0);
    chk(rdyObs == 1'b1, "R5", int'(rdyObs), 1);
    expRel("R5", 10);
    chk(relUnit == 2'd0, "R10", int'(relUnit), 0);
    chk(relSrcA == 5'd1, "R10", int'(relSrcA), 1);
    chk(relSrcB == 5'd2, "R10", int'(relSrcB), 2);
    cyc(0, 0, 0, 0, 0, 1, 10);
    chk(relValid == 1'b0, "R8", int'(relValid), 0);

    // R6, R9: divide -> dependent add waits, later sub overtakes it
    cyc(1, 3, 2, 3, 1, 0, 0);
    expRel("R5", 1);
    chk(relUnit == 2'd3, "R10", int'(relUnit), 3);
    cyc(1, 1, 1, 5, 4, 0, 0);
    chk(relValid == 1'b0, "R6", int'(relValid), 0);
    cyc(1, 2, 7, 8, 6, 0, 0);
    expRel("R9", 6);
    chk(relUnit == 2'd2, "R9", int'(relUnit), 2);
    idle();
    chk(relValid == 1'b0, "R6", int'(relValid), 0);
    idle();
    chk(relValid == 1'b0, "R6", int'(relValid), 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    expRel("R6", 4);
    chk(relSrcB == 5'd5, "R10", int'(relSrcB), 5);
    cyc(0, 0, 0, 0, 0, 1, 6);
    chk(relValid == 1'b0, "R8", int'(relValid), 0);
    cyc(0, 0, 0, 0, 0, 1, 4);

    // R4, R11: second writer of a register waits for the broadcast
    cyc(1, 0, 3, 3, 9, 0, 0);
    expRel("R5", 9);
    cyc(1, 1, 0, 0, 9, 0, 0);
    chk(rdyObs == 1'b0, "R4", int'(rdyObs), 0);
    chk(relValid == 1'b0, "R4", int'(relValid), 0);
    cyc(1, 1, 0, 0, 9, 1, 9);
    chk(rdyObs == 1'b0, "R4", int'(rdyObs), 0);
    cyc(1, 1, 0, 0, 9, 0, 0);
    chk(rdyObs == 1'b1, "R11", int'(rdyObs), 1);
    expRel("R11", 9);
    cyc(0, 0, 0, 0, 0, 1, 9);

    // R7: broadcast in the accepting cycle counts as ready
    cyc(1, 3, 0, 0, 12, 0, 0);
    expRel("R5", 12);
    cyc(1, 0, 12, 12, 13, 1, 12);
    expRel("R7", 13);
    cyc(0, 0, 0, 0, 0, 1, 13);

    // R3, R8: fill with eight dependents, then drain in age order
    cyc(1, 0, 0, 0, 20, 0, 0);
    expRel("R5", 20);
    for (int k = 0; k < 8; k++) begin
      cyc(1, k % 4, 20, 20, 21 + k, 0, 0);
      chk(rdyObs == 1'b1, "R3", int'(rdyObs), 1);
      chk(relValid == 1'b0, "R6", int'(relValid), 0);
    end
    cyc(1, 0, 0, 0, 29, 0, 0);
    chk(rdyObs == 1'b0, "R3", int'(rdyObs), 0);
    cyc(0, 0, 0, 0, 0, 1, 20);
    expRel("R8", 21);
    chk(relUnit == 2'd0, "R8", int'(relUnit), 0);
    for (int k = 1; k < 8; k++) begin
      idle();
      expRel("R8", 21 + k);
      chk(relUnit == 2'(k % 4), "R8", int'(relUnit), k % 4);
    end
    idle();
    chk(relValid == 1'b0, "R8", int'(relValid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule